// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent 16-bit count registers. Each one either counts divided-down system clock cycles or counts falling edges seen on its own event pin. A shared prescaler divides the clock by 12, or by 4 when the fast option is set. A per-timer gate pin can hold counting off whenever that timer's gate option is enabled.

Software reaches the count bytes, the control byte, the overflow flags and the prescale option through a small byte-wide register port. Writes take effect at a clock edge, and the read data is a combinational function of the address. Each timer has two overflow outputs. The first is a sticky flag that software clears. The second is a single-cycle tick that a serial port can use as its baud clock.

The register map is as follows:

| Address | Contents |
|---|---|
| 0 | Timer 0 low byte |
| 1 | Timer 0 high byte |
| 2 | Timer 1 low byte |
| 3 | Timer 1 high byte |
| 4 | Control byte |
| 5 | Flags, write 1 to clear |
| 6 | Prescale option |

The control byte holds one 4-bit nibble per timer. Timer 0 uses bits 3:0 and timer 1 uses bits 7:4. Within a nibble:

- bit 0 is run;
- bit 1 selects event-count mode;
- bit 2 enables gating;
- bit 3 selects 8-bit reload mode.

Top module: `dual_tmr_cnt`

## Requirements
- R1: After reset every register reads 0x00, and both overflow flags and both ticks are low.
- R2: A write stores its byte at the addressed location, and a read returns it. Timer i low byte is at address 2i, its high byte at 2i+1, the control byte at 4 and the prescale option at 6, bit 0.
- R3: A prescale tick occurs every 12 clocks after reset, or every 4 when the prescale option is 1. In timer mode an enabled count advances once per tick.
- R4: Each event pin is sampled every clock. In event mode, an enabled count advances once for each high-to-low change between two successive samples.
- R5: A count is enabled only when its run bit is 1 and either gating is off or its gate pin is high. Otherwise the count holds its value.
- R6: In 16-bit mode the count wraps from 0xFFFF to 0x0000 and sets that timer's overflow flag.
- R7: In reload mode only the low byte counts. When it advances from 0xFF it takes the high byte's value, the high byte stays unchanged, and the flag is set.
- R8: An overflow flag stays set until 1 is written to its bit (bit i for timer i) at address 5. An overflow in the same cycle as that clear leaves the flag set.
- R9: A write to either count byte of a timer cancels that timer's increment, and any overflow, in the same cycle.
- R10: The tick output pulses high for exactly one cycle. It rises in the same cycle as the flag is set by each overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ev_pin | input | 2 | Event input per timer |
| gate_pin | input | 2 | Gate input per timer |
| ovf_flag | output | 2 | Sticky overflow flag per timer |
| baud_tick | output | 2 | One-cycle overflow pulse per timer |

## Verification
The hardest case to reach from the ports is a software clear that lands on the exact edge where the same timer overflows. The stimulus builds this case deliberately. Timer 0 runs in reload mode with a high byte of 0xFF and the fast prescale, so it overflows every fourth clock. The clear strobe is then held high for twelve consecutive cycles, which forces at least one clear to coincide with an overflow.

A similar held write to the low byte exposes whether writes take priority over increments. A per-clock behavioural model tracks the prescaler phase, the pin samples and every register, and the bench compares it against the outputs throughout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned N_TMR  = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(2 * N_TMR);
  localparam logic [ADDR_W-1:0] FLG_ADDR = ADDR_W'(2 * N_TMR + 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(2 * N_TMR + 2);

  // per-timer control nibble, bit 0 is run
  typedef struct packed {
    logic reload;
    logic gate_en;
    logic ev_mode;
    logic run;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(SLOW_DIV);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] lim;

  always_comb begin
    lim    = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
    tick_o = (pcnt_q >= lim);
    pcnt_d = tick_o ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: a tick restarts the divider, so two ticks never touch
  a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_o
);
  logic samp_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= pin;
      prev_q <= samp_q;
    end
  end

  assign fall_o = prev_q & ~samp_q;

  // R4: one fall is followed by a low sample, never a second fall
  a_r4_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_ctl_t          ctl,
  input  logic              gate_pin,
  input  logic              ptick,
  input  logic              fall,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              clr_flag,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              tick_o
);
  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              flag_d;
  logic              gate_ok, cnt_en, step, ovf;

  always_comb begin
    gate_ok = ~ctl.gate_en | gate_pin;
    cnt_en  = ctl.run & gate_ok;
    step    = cnt_en & (ctl.ev_mode ? fall : ptick) & ~(wr_lo | wr_hi);
    lo_d    = lo_q;
    hi_d    = hi_q;
    ovf     = 1'b0;
    if (step) begin
      if (ctl.reload) begin
        if (&lo_q) begin
          lo_d = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end else begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ovf          = &{hi_q, lo_q};
      end
    end
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
    flag_d = ovf ? 1'b1 : (clr_flag ? 1'b0 : flag_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      flag_o <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      flag_o <= flag_d;
      tick_o <= ovf;
    end
  end

  assign cnt_o = {hi_q, lo_q};

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctl.run || (ctl.gate_en && !gate_pin)) && !wr_lo && !wr_hi)
      |=> $stable(cnt_o));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctl.reload && (&cnt_o)) |=> (cnt_o == '0 && flag_o && tick_o));

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctl.reload && (&lo_q)) |=> (lo_q == $past(hi_q) && hi_q == $past(hi_q)));

  a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_flag));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));

  a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  a_r10_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> flag_o);
endmodule

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt
  import tmr_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [N_TMR-1:0]  ev_pin,
  input  logic [N_TMR-1:0]  gate_pin,
  output logic [N_TMR-1:0]  ovf_flag,
  output logic [N_TMR-1:0]  baud_tick
);
  logic [BYTE_W-1:0] ctl_q, ctl_d;
  logic              fast_q, fast_d;
  logic              ptick;
  logic [CNT_W-1:0]  cnt [N_TMR];
  logic [N_TMR-1:0]  fall;

  always_comb begin
    ctl_d  = ctl_q;
    fast_d = fast_q;
    if (reg_wr && reg_addr == CTL_ADDR) ctl_d  = reg_wdata;
    if (reg_wr && reg_addr == PRE_ADDR) fast_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      fast_q <= fast_d;
    end
  end

  tmr_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .fast(fast_q), .tick_o(ptick));

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(2 * i + 1);
    tmr_ctl_t ctl_i;
    assign ctl_i = tmr_ctl_t'(ctl_q[CTL_W*i +: CTL_W]);

    tmr_edge u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ev_pin[i]), .fall_o(fall[i]));

    tmr_core u_core (
      .clk(clk), .rst_n(rst_n), .ctl(ctl_i), .gate_pin(gate_pin[i]),
      .ptick(ptick), .fall(fall[i]),
      .wr_lo(reg_wr && reg_addr == LO_A),
      .wr_hi(reg_wr && reg_addr == HI_A),
      .wdata(reg_wdata),
      .clr_flag(reg_wr && reg_addr == FLG_ADDR && reg_wdata[i]),
      .cnt_o(cnt[i]), .flag_o(ovf_flag[i]), .tick_o(baud_tick[i]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (reg_addr == ADDR_W'(2 * i))     reg_rdata = cnt[i][BYTE_W-1:0];
      if (reg_addr == ADDR_W'(2 * i + 1)) reg_rdata = cnt[i][CNT_W-1:BYTE_W];
    end
    if (reg_addr == CTL_ADDR) reg_rdata = ctl_q;
    if (reg_addr == FLG_ADDR) reg_rdata = BYTE_W'(ovf_flag);
    if (reg_addr == PRE_ADDR) reg_rdata = BYTE_W'(fast_q);
  end

  // R2: a control write is visible on the next read
  a_r2_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTL_ADDR) |=> (ctl_q == $past(reg_wdata)));
endmodule

// File: tb/dual_tmr_cnt_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_cnt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ev_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_flag, baud_tick;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  dual_tmr_cnt dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pin(ev_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag), .baud_tick(baud_tick));

  // behavioural reference model
  int m_lo [2], m_hi [2];
  bit m_flag [2], m_tick [2], m_samp [2], m_prev [2];
  int m_pcnt;
  bit m_fast;
  int m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_flag[i] = 0; m_tick[i] = 0;
        m_samp[i] = 0; m_prev[i] = 0;
      end
      m_pcnt = 0; m_fast = 0; m_ctl = 0;
    end else begin
      int lim;
      bit pt;
      lim = m_fast ? 4 : 12;
      pt = (m_pcnt >= lim - 1);
      for (int i = 0; i < 2; i++) begin
        int nib, v;
        bit en, src, wl, wh, ov, clr;
        nib = (m_ctl >> (4 * i)) & 15;
        en  = nib[0] && (!nib[2] || gate_pin[i]);
        src = nib[1] ? (m_prev[i] && !m_samp[i]) : pt;
        wl  = reg_wr && reg_addr == 3'(2 * i);
        wh  = reg_wr && reg_addr == 3'(2 * i + 1);
        ov  = 0;
        if (en && src && !wl && !wh) begin
          if (nib[3]) begin
            if (m_lo[i] == 255) begin m_lo[i] = m_hi[i]; ov = 1; end
            else m_lo[i] = m_lo[i] + 1;
          end else begin
            v = m_hi[i] * 256 + m_lo[i] + 1;
            if (v == 65536) begin v = 0; ov = 1; end
            m_hi[i] = v / 256; m_lo[i] = v % 256;
          end
        end
        if (wl) m_lo[i] = reg_wdata;
        if (wh) m_hi[i] = reg_wdata;
        clr = reg_wr && reg_addr == 3'd5 && reg_wdata[i];
        m_flag[i] = ov ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
        m_tick[i] = ov;
      end
      if (reg_wr && reg_addr == 3'd4) m_ctl = reg_wdata;
      if (reg_wr && reg_addr == 3'd6) m_fast = reg_wdata[0];
      m_pcnt = pt ? 0 : m_pcnt + 1;
      for (int i = 0; i < 2; i++) begin
        m_prev[i] = m_samp[i];
        m_samp[i] = ev_pin[i];
      end
    end
  end

  function automatic int exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lo[0];
      3'd1: return m_hi[0];
      3'd2: return m_lo[1];
      3'd3: return m_hi[1];
      3'd4: return m_ctl;
      3'd5: return {m_flag[1], m_flag[0]};
      3'd6: return m_fast;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the clock edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk(cur_tag, reg_rdata, exp_read(reg_addr), "read data vs model");
      chk("R8", ovf_flag, {m_flag[1], m_flag[0]}, "flags vs model");
      chk("R10", baud_tick, {m_tick[1], m_tick[0]}, "ticks vs model");
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(tag, reg_rdata, exp, "directed read");
  endtask

  // spacing between two successive low-byte changes of timer 0
  task automatic measure(input int period, input string tag);
    int first;
    bit got;
    logic [7:0] prev;
    first = -1; got = 0;
    @(negedge clk);
    reg_addr = 3'd0;
    #2 prev = reg_rdata;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      #2;
      if (reg_rdata != prev) begin
        if (first < 0) first = k;
        else begin
          chk(tag, k - first, period, "increment spacing");
          got = 1;
        end
        prev = reg_rdata;
      end
    end
    if (!got) chk(tag, 0, period, "no increments seen");
  endtask

  task automatic pulse_ev(input int i);
    @(negedge clk); ev_pin[i] = 1'b0;
    idle(2);
    ev_pin[i] = 1'b1;
    idle(2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 0, "R1");
    chk("R1", ovf_flag, 0, "flags after reset");
    chk("R1", baud_tick, 0, "ticks after reset");

    // R2: byte map, control not counting
    cur_tag = "R2";
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'hCD); wr(3'd3, 8'hAB);
    rd_chk(3'd0, 8'h34, "R2"); rd_chk(3'd1, 8'h12, "R2");
    rd_chk(3'd2, 8'hCD, "R2"); rd_chk(3'd3, 8'hAB, "R2");
    wr(3'd4, 8'hA5); // timer0 run+gate (gate low), timer1 event+reload, no run
    rd_chk(3'd4, 8'hA5, "R2");
    // R5: gated off, run set
    cur_tag = "R5";
    idle(40);
    rd_chk(3'd0, 8'h34, "R5"); rd_chk(3'd1, 8'h12, "R5");
    wr(3'd6, 8'h01);
    rd_chk(3'd6, 1, "R2");
    wr(3'd6, 8'h00);

    // R3: slow and fast prescale in timer mode
    cur_tag = "R3";
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    measure(12, "R3");
    wr(3'd6, 8'h01);
    measure(4, "R3");
    wr(3'd4, 8'h05); // gating on, gate low: hold
    cur_tag = "R5";
    @(negedge clk) reg_addr = 3'd0;
    #2 base = reg_rdata;
    idle(30);
    rd_chk(3'd0, base, "R5");
    gate_pin[0] = 1'b1;
    measure(4, "R5");
    gate_pin[0] = 1'b0;

    // R4: event mode on timer 1 with gate
    cur_tag = "R4";
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'h70); // timer1 run, event, gate on, gate pin low
    for (int k = 0; k < 3; k++) pulse_ev(1);
    rd_chk(3'd2, 0, "R5");
    gate_pin[1] = 1'b1;
    for (int k = 0; k < 5; k++) pulse_ev(1);
    rd_chk(3'd2, 5, "R4");
    wr(3'd4, 8'h30); // gating off, gate pin low
    gate_pin[1] = 1'b0;
    for (int k = 0; k < 2; k++) pulse_ev(1);
    rd_chk(3'd2, 7, "R4");

    // R6: 16-bit wrap on timer 0, fast prescale
    cur_tag = "R6";
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hFD); wr(3'd1, 8'hFF);
    wr(3'd4, 8'h01);
    idle(20);
    wr(3'd4, 8'h00);
    chk("R6", ovf_flag[0], 1, "flag after wrap");
    rd_chk(3'd1, 8'h00, "R6");

    // R7: reload mode on timer 1
    cur_tag = "R7";
    wr(3'd5, 8'h03);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hF0);
    wr(3'd4, 8'h90);
    idle(10);
    wr(3'd4, 8'h00);
    chk("R7", ovf_flag[1], 1, "flag after reload");
    rd_chk(3'd3, 8'hF0, "R7");

    // R8: clear held high while timer 0 overflows every 4 clocks
    cur_tag = "R8";
    wr(3'd5, 8'h03);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd4, 8'h09);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h01;
    idle(12);
    reg_wr = 1'b0;
    idle(6);
    wr(3'd4, 8'h00);
    chk("R8", ovf_flag[0], 1, "flag set before sticky wait");
    idle(25);
    chk("R8", ovf_flag[0], 1, "flag sticky while idle");
    wr(3'd5, 8'h02);
    chk("R8", ovf_flag[0], 1, "other bit clear leaves flag");
    wr(3'd5, 8'h01);
    chk("R8", ovf_flag[0], 0, "W1C clears flag");

    // R9: held low-byte write blocks counting and overflow
    cur_tag = "R9";
    wr(3'd4, 8'h09);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hFF;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      #2;
      chk("R9", reg_rdata, 8'hFF, "written byte holds");
      chk("R10", baud_tick[0], 0, "no tick while writing");
    end
    reg_wr = 1'b0;
    wr(3'd4, 8'h00);
    idle(5);
    finish_run();
  end
endmodule